// File: doc/BRIEF.md
# Two-Slot Alternating DMA Channel

This block is a single peripheral DMA channel with two descriptor slots, A and B. Each slot holds a word-aligned start address and a 13-bit byte count. Once software arms a slot and the channel is running, the channel walks that slot's address upward one byte per accepted memory beat. When the slot's count runs out, the channel marks the slot finished and switches to the other slot. Software can refill the idle slot while the active one drains, so the data stream has no gap between buffers.

All control goes through a 32-byte register window. A single 8-bit status word carries the run and interrupt-enable controls, the per-slot arm and finished flags, an error flag and a slot pointer. The status word has one offset that sets bits, one that clears bits and one that only reads. A mode register holds the transfer direction, byte order, burst size, data width and a peripheral selector. Only the direction bit drives hardware here: it becomes `mem_write`. The memory side is a simple request/acknowledge pair, and the address advances only on a cycle where both are high.

Top module: `pingpong_dma_chan`

## Requirements
- R1: After reset, every register reads zero, `mem_req` is low and `irq` is low.
- R2: Status bits are: 0 run, 1 interrupt enable, 2 error, 3 A finished, 4 A armed, 5 B finished, 6 B armed, 7 slot pointer (0 = A active, 1 = B active). A write to offset 0x04 ORs data bits 6:0 into the status word. A write to offset 0x08 clears the status bits where the data has ones. Zero data bits have no effect. Bit 7 cannot be written. Offsets 0x04, 0x08 and 0x0C all read the status word.
- R3: Offset 0x00 holds mode bits 7:0 and reads back zero above them. Mode bit 0 (1 = peripheral to memory) drives `mem_write`.
- R4: Slot A uses offsets 0x10 (start) and 0x14 (count). Slot B uses 0x18 and 0x1C. A start write forces address bits 1:0 to zero. A count write keeps only bits 12:0. Reads return the live address and the remaining count.
- R5: While run is set and the active slot is armed with a nonzero count, `mem_req` is high and `mem_addr` equals the slot's address. Each cycle with `mem_ack` high advances the address by one and lowers the count by one. Without `mem_ack`, both hold.
- R6: On the last beat of a slot, the channel clears that slot's arm bit, sets its finished bit and toggles the slot pointer.
- R7: When both slots are armed, the other slot's transfer starts right after the first slot ends, with no software action.
- R8: `irq` is high exactly when interrupt enable is set and at least one of error, A finished or B finished is set. Clearing those bits through offset 0x08 drops it.
- R9: Clearing run lowers `mem_req` and freezes the slot address and count. Setting run again continues from the same byte.
- R10: With run set and the active slot unarmed, the channel issues no requests, even if the other slot is armed. It starts once the active slot is armed.
- R11: An armed active slot with zero count finishes one cycle later, with no memory request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| mem_req | output | 1 | Memory beat request |
| mem_addr | output | ADDR_W | Byte address of the current beat |
| mem_write | output | 1 | Beat direction, copied from mode bit 0 |
| mem_ack | input | 1 | Beat accepted this cycle |
| irq | output | 1 | Interrupt request |

## Verification
Directed runs cover several cases:
- Both slots armed back to back, which separates correct slot chaining from stalling after slot A.
- The inactive slot armed while the active slot is not, which shows the pointer rather than any armed bit picks the work.
- A pause in mid-slot, which shows whether run gates only the request or also the counters.
- A zero-count slot, which shows whether completion is taken without a beat.

Random rounds program the active slot with random aligned addresses and counts from zero up. They acknowledge beats with a random pattern, so stalls fall in every position, including on the last beat. The first and last beat address, the beat count and the slot pointer are checked after each round.

// File: rtl/pingpong_dma_chan.sv
module pingpong_dma_chan #(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 13,
  parameter int MODE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [4:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_write,
  input  logic              mem_ack,
  output logic              irq
);
  localparam logic [4:0] OFF_MODE = 5'h00;
  localparam logic [4:0] OFF_SET  = 5'h04;
  localparam logic [4:0] OFF_CLR  = 5'h08;
  localparam logic [4:0] OFF_STAT = 5'h0C;
  localparam logic [4:0] OFF_SLOT = 5'h10;

  logic [7:0]        stat, stat_nxt;
  logic [MODE_W-1:0] mode;
  logic [ADDR_W-1:0] sa [2];
  logic [CNT_W-1:0]  sc [2];

  logic act, act_armed, busy, beat, fin;
  logic [CNT_W-1:0] cur_cnt;

  assign act       = stat[7];
  assign act_armed = act ? stat[6] : stat[4];
  assign busy      = stat[0] & act_armed;
  assign cur_cnt   = sc[act];
  assign mem_req   = busy && (cur_cnt != '0);
  assign mem_addr  = sa[act];
  assign mem_write = mode[0];
  assign beat      = mem_req & mem_ack;
  assign fin       = busy & ((cur_cnt == '0) | (beat & (cur_cnt == CNT_W'(1))));
  assign irq       = stat[1] & (stat[2] | stat[3] | stat[5]);

  wire wr_set = reg_we && reg_addr == OFF_SET;
  wire wr_clr = reg_we && reg_addr == OFF_CLR;

  always_comb begin
    stat_nxt = stat;
    if (fin) begin
      if (act) begin
        stat_nxt[6] = 1'b0;
        stat_nxt[5] = 1'b1;
      end else begin
        stat_nxt[4] = 1'b0;
        stat_nxt[3] = 1'b1;
      end
      stat_nxt[7] = ~stat[7];
    end
    if (wr_set) stat_nxt[6:0] = stat_nxt[6:0] | reg_wdata[6:0];
    if (wr_clr) stat_nxt[6:0] = stat_nxt[6:0] & ~reg_wdata[6:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stat <= '0;
      mode <= '0;
      for (int s = 0; s < 2; s++) begin
        sa[s] <= '0;
        sc[s] <= '0;
      end
    end else begin
      stat <= stat_nxt;
      if (reg_we && reg_addr == OFF_MODE) mode <= reg_wdata[MODE_W-1:0];
      for (int s = 0; s < 2; s++) begin
        if (reg_we && reg_addr == OFF_SLOT + 5'(8*s))
          sa[s] <= {reg_wdata[ADDR_W-1:2], 2'b00};
        else if (beat && act == 1'(s))
          sa[s] <= sa[s] + ADDR_W'(1);
        if (reg_we && reg_addr == OFF_SLOT + 5'(8*s + 4))
          sc[s] <= reg_wdata[CNT_W-1:0];
        else if (beat && act == 1'(s))
          sc[s] <= sc[s] - CNT_W'(1);
      end
    end
  end

  always_comb begin
    case (reg_addr)
      OFF_MODE:                   reg_rdata = 32'(mode);
      OFF_SET, OFF_CLR, OFF_STAT: reg_rdata = 32'(stat);
      5'h10:                      reg_rdata = 32'(sa[0]);
      5'h14:                      reg_rdata = 32'(sc[0]);
      5'h18:                      reg_rdata = 32'(sa[1]);
      5'h1C:                      reg_rdata = 32'(sc[1]);
      default:                    reg_rdata = '0;
    endcase
  end

  assert_addr_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack && !reg_we |=> mem_req && $stable(mem_addr));
  assert_addr_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_ack && !reg_we && cur_cnt > CNT_W'(1)
    |=> mem_req && mem_addr == $past(mem_addr) + ADDR_W'(1));
  assert_ptr_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> $stable(stat[7]));
  assert_last_beat_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_ack && cur_cnt == CNT_W'(1) |=> stat[7] != $past(stat[7]));
  assert_irq_ack_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_clr && reg_wdata[2] && reg_wdata[3] && reg_wdata[5] |=> !irq);
  assert_pause_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !stat[0] |-> !mem_req);
  assert_zero_cnt_R11: assert property (@(posedge clk) disable iff (!rst_n)
    busy && cur_cnt == '0 && !reg_we |-> !mem_req ##1 stat[7] != $past(stat[7]));
endmodule

// File: tb/pingpong_dma_chan_bench.sv
`timescale 1ns/1ps
module pingpong_dma_chan_bench;
  localparam logic [4:0] MODE = 5'h00, SET = 5'h04, CLR = 5'h08, STAT = 5'h0C;
  localparam logic [4:0] A_ST = 5'h10, A_CN = 5'h14, B_ST = 5'h18, B_CN = 5'h1C;
  localparam logic [7:0] RUN = 8'h01, IE = 8'h02, ERR = 8'h04, DA = 8'h08,
                         SA = 8'h10, DB = 8'h20, SB = 8'h40, BIU = 8'h80;

  logic clk = 0, rst_n = 0, reg_we = 0, mem_ack, mem_req, mem_write, irq;
  logic [4:0] reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata, mem_addr;
  logic ack_force = 0, rnd_mode = 0, rnd_bit = 0;
  int checks = 0, fails = 0, beats = 0;
  logic [31:0] first_addr, last_addr;
  logic [31:0] log_addr [64];
  logic exp_biu = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;
  assign mem_ack = rnd_mode ? rnd_bit : ack_force;

  pingpong_dma_chan u_pingpong_dma_chan (
    .clk, .rst_n, .reg_we, .reg_addr, .reg_wdata, .reg_rdata,
    .mem_req, .mem_addr, .mem_write, .mem_ack, .irq);

  always @(negedge clk) begin
    rnd_bit = 1'($urandom_range(0, 1));
    #1;
    if (mem_req && mem_ack) begin
      if (beats == 0) first_addr = mem_addr;
      if (beats < 64) log_addr[beats] = mem_addr;
      last_addr = mem_addr;
      beats++;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] v);
    @(negedge clk);
    reg_addr = a;
    #0.5 v = reg_rdata;
  endtask

  task automatic wait_bit(input logic [7:0] m, output bit ok);
    logic [31:0] v;
    ok = 0;
    for (int i = 0; i < 3000; i++) begin
      rd(STAT, v);
      if ((v[7:0] & m) != 0) begin ok = 1; break; end
    end
  endtask

  function automatic logic [7:0] fin_mask(input logic s);
    return s ? DB : DA;
  endfunction
  function automatic logic [7:0] arm_mask(input logic s);
    return s ? SB : SA;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, base;
    bit ok;
    int cnt;
    void'($urandom(32'h5eed));
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1 reset state
    for (int i = 0; i < 8; i++) begin
      rd(5'(i * 4), v);
      chk("R1 reg zero", v, 0);
    end
    chk("R1 mem_req", 32'(mem_req), 0);
    chk("R1 irq", 32'(irq), 0);

    // R3 mode
    wr(MODE, 32'hFFFF_FFA5);
    rd(MODE, v); chk("R3 mode readback", v, 32'hA5);
    chk("R3 mem_write high", 32'(mem_write), 1);
    wr(MODE, 32'h4);
    chk("R3 mem_write low", 32'(mem_write), 0);

    // R4 alignment and width
    wr(A_ST, 32'h1003); rd(A_ST, v); chk("R4 start aligned", v, 32'h1000);
    wr(A_CN, 32'hFFFF); rd(A_CN, v); chk("R4 count 13 bits", v, 32'h1FFF);

    // R2 set/clear
    wr(SET, {24'h0, IE | BIU}); rd(STAT, v); chk("R2 set ie, biu not writable", v, 32'(IE));
    wr(CLR, 0); rd(CLR, v); chk("R2 zero clear no effect", v, 32'(IE));
    wr(SET, 0); rd(SET, v); chk("R2 zero set no effect", v, 32'(IE));
    wr(CLR, 32'(IE)); rd(STAT, v); chk("R2 clear ie", v, 0);

    // R10 idle with other slot armed, then R5/R7 chaining
    wr(A_ST, 32'h100); wr(A_CN, 4);
    wr(B_ST, 32'h200); wr(B_CN, 3);
    ack_force = 1; beats = 0;
    wr(SET, 32'(RUN | SB));
    repeat (4) @(negedge clk);
    chk("R10 no request while A unarmed", 32'(mem_req), 0);
    chk("R10 no beats", 32'(beats), 0);
    wr(SET, 32'(SA));
    wait_bit(DB, ok);
    chk("R7 B finished", 32'(ok), 1);
    chk("R5 beat total", 32'(beats), 7);
    for (int i = 0; i < 4; i++) chk("R5 A address", log_addr[i], 32'h100 + 32'(i));
    for (int i = 0; i < 3; i++) chk("R7 B address", log_addr[4 + i], 32'h200 + 32'(i));
    rd(STAT, v); chk("R6 status after both", v, 32'(RUN | DA | DB));
    rd(A_ST, v); chk("R4 live address", v, 32'h104);
    rd(B_CN, v); chk("R4 live count", v, 0);

    // R8 interrupt
    chk("R8 irq masked", 32'(irq), 0);
    wr(SET, 32'(IE)); chk("R8 irq on done", 32'(irq), 1);
    wr(CLR, 32'(DA | DB)); chk("R8 irq acked", 32'(irq), 0);
    wr(SET, 32'(ERR)); chk("R8 irq on error", 32'(irq), 1);
    wr(CLR, 32'(ERR | IE)); chk("R8 irq off", 32'(irq), 0);

    // R9 pause and resume
    ack_force = 0;
    wr(A_ST, 32'h400); wr(A_CN, 10);
    beats = 0;
    wr(SET, 32'(SA));
    @(negedge clk); ack_force = 1;
    repeat (3) @(negedge clk);
    ack_force = 0;
    wr(CLR, 32'(RUN));
    rd(A_CN, v); chk("R9 count frozen", v, 7);
    rd(A_ST, v); chk("R9 address frozen", v, 32'h403);
    repeat (5) @(negedge clk);
    chk("R9 no request paused", 32'(mem_req), 0);
    rd(A_CN, v); chk("R9 count still frozen", v, 7);
    ack_force = 1;
    wr(SET, 32'(RUN));
    wait_bit(DA, ok);
    chk("R9 resumed to done", 32'(ok), 1);
    chk("R9 total beats", 32'(beats), 10);
    chk("R9 last address", last_addr, 32'h409);
    exp_biu = 1;
    rd(STAT, v); chk("R6 pointer to B", 32'(v[7]), 1);

    // R11 zero count
    wr(CLR, 32'(DA | DB));
    wr(B_CN, 0);
    beats = 0;
    wr(SET, 32'(SB));
    repeat (2) @(negedge clk);
    rd(STAT, v);
    chk("R11 done set", 32'(v[7:0] & (DB | SB)), 32'(DB));
    chk("R11 pointer toggled", 32'(v[7]), 0);
    chk("R11 no beats", 32'(beats), 0);
    exp_biu = 0;

    // random rounds: R5 R6 R7
    for (int r = 0; r < 24; r++) begin
      base = {14'h0, 16'($urandom_range(0, 16'hFFFF)), 2'b00};
      cnt = $urandom_range(0, 24);
      wr(CLR, 32'(DA | DB));
      wr(exp_biu ? B_ST : A_ST, base);
      wr(exp_biu ? B_CN : A_CN, 32'(cnt));
      beats = 0;
      rnd_mode = 1;
      wr(SET, 32'(arm_mask(exp_biu)));
      wait_bit(fin_mask(exp_biu), ok);
      rnd_mode = 0;
      chk("R6 random done", 32'(ok), 1);
      chk("R5 random beats", 32'(beats), 32'(cnt));
      if (cnt > 0) begin
        chk("R5 random first", first_addr, base);
        chk("R5 random last", last_addr, base + 32'(cnt) - 1);
      end
      rd(STAT, v);
      chk("R6 random arm cleared", 32'(v[7:0] & arm_mask(exp_biu)), 0);
      exp_biu = ~exp_biu;
      chk("R6 random pointer", 32'(v[7]), 32'(exp_biu));
    end

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule